// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one channel of a 16-bit timer. It measures the time between successive valid edges on an input pin. A software strobe starts the channel: the counter clears and then counts up on each pulse of an external count-clock enable. When a valid edge arrives on the pin, several things happen on the same clock edge. The running count is copied into a capture register, the counter restarts from zero, and a one-cycle interrupt pulse is raised. A flag stored next to the captured value records whether the counter wrapped past its maximum at any time during that period.

The pin is synchronized by two flops and can optionally pass through a noise filter before edge detection. The edge polarity is selectable. Once the channel is running, the same software strobe forces a capture, which is handled exactly like a pin edge. A stop input halts the channel. Software reconstructs the interval as `tick period × (65536 × flag + captured + 1)`. This result is exact only when the counter wrapped at most once during the period.

Top module: `pulse_interval_timer`

## Requirements
- R1: While the channel is off, a one-cycle `chanStartCap` pulse turns it on (`chanOn` = 1 from the next cycle) and restarts the counter at 0. Pin edges seen before that start produce no capture.
- R2: The counter is 16 bits wide. It advances by one only on clock edges where `countTick` is 1 and the channel is running. The captured value equals the number of ticks strictly between the start or previous capture edge and the capture edge.
- R3: On a capture, `capData` takes the count, the counter restarts at 0 and `capIrq` is 1 for exactly the following cycle. All of these happen on the same clock edge. With the filter off, a pin change is captured on the third rising clock edge after the change.
- R4: At each capture, `capOvf` becomes 1 if the counter wrapped from FFFFh to 0000h since the previous capture or start, and 0 otherwise. Several wraps still give 1.
- R5: A `chanStartCap` pulse while the channel is on causes a capture on that same clock edge.
- R6: `edgeSel` chooses the valid edges: 2'b01 is rising, 2'b10 is falling, 2'b11 is both and 2'b00 is none. Edges of a polarity that is not selected cause no capture.
- R7: With `filtEn` = 1, a new pin level is accepted only after three consecutive equal synchronized samples. A pulse lasting two clock cycles is ignored. An accepted change is captured on the sixth rising clock edge after the pin changes.
- R8: `chanStop` turns the channel off (`chanOn` = 0) and stops counting. It wins over `chanStartCap` in the same cycle. While the channel is off, pin edges cause no capture, and `capData` and `capOvf` keep their last values.
- R9: After reset, `capData` = 0, `capOvf` = 0, `capIrq` = 0 and `chanOn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countTick | input | 1 | Count-clock enable |
| chanStartCap | input | 1 | Software strobe: starts the channel when off, captures when on |
| chanStop | input | 1 | Stops the channel |
| pinIn | input | 1 | Raw measured input |
| edgeSel | input | 2 | Valid-edge select (01 rising, 10 falling, 11 both) |
| filtEn | input | 1 | Enables the three-sample noise filter |
| capData | output | 16 | Captured count |
| capOvf | output | 1 | Counter wrapped during the captured period |
| capIrq | output | 1 | One-cycle capture pulse |
| chanOn | output | 1 | Channel running |

## Verification
A software capture becomes visible in the cycle after the clock edge that samples the strobe. An unfiltered pin change becomes visible after the third edge, and a filtered one after the sixth. Each driver call records the capture edge it expects, together with a tick count and an overflow flag computed from the requirements. The monitor checks each interrupt pulse against the capture edge number as well as the data, so any latency slip is reported. An interrupt with nothing queued counts as a mismatch, and so does an item still queued when a test phase settles. This covers the ignored-edge cases.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic start;    // clear counter and overflow history
    logic capture;  // load capture register, clear counter
    logic run;      // channel counting this cycle
  } ipt_strobe_t;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/ipt_input_cond.sv
module ipt_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter bit HAS_FILTER  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       filtEn,
  input  logic [1:0] edgeSel,
  output logic       edgeHit
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   level;
  logic                   prevLvl;
  logic                   riseHit;
  logic                   fallHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  generate
    if (HAS_FILTER) begin : g_filter
      logic [FILT_LEN-2:0] histQ;
      logic [FILT_LEN-1:0] sampleWin;
      logic                fLvl;

      assign sampleWin = {histQ, syncOut};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          histQ <= '0;
          fLvl  <= 1'b0;
        end else begin
          histQ <= sampleWin[FILT_LEN-2:0];
          if (&sampleWin)       fLvl <= 1'b1;
          else if (~|sampleWin) fLvl <= 1'b0;
        end
      end

      assign level = filtEn ? fLvl : syncOut;

      // R7: filtered level only moves after a full window of equal samples
      a_r7_filter_settle: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(fLvl) |-> $past(sampleWin) == {FILT_LEN{fLvl}});
    end else begin : g_nofilter
      assign level = syncOut;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= level;
  end

  assign riseHit = level & ~prevLvl;
  assign fallHit = ~level & prevLvl;
  assign edgeHit = (edgeSel[0] & riseHit) | (edgeSel[1] & fallHit);
endmodule

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
  import ipt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swTrig,
  input  logic        swStop,
  input  logic        edgeHit,
  output logic        chanOn,
  output ipt_strobe_t stb
);
  logic onQ;

  always_comb begin
    stb.start   = swTrig & ~onQ & ~swStop;
    stb.capture = onQ & ~swStop & (swTrig | edgeHit);
    stb.run     = onQ & ~swStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          onQ <= 1'b0;
    else if (swStop)    onQ <= 1'b0;
    else if (stb.start) onQ <= 1'b1;
  end

  assign chanOn = onQ;

  // R8: stop always leaves the channel off
  a_r8_stop_off: assert property (@(posedge clk) disable iff (!rstN)
    swStop |=> !chanOn);
  // R1: strobe while idle turns the channel on
  a_r1_start_on: assert property (@(posedge clk) disable iff (!rstN)
    !chanOn && swTrig && !swStop |=> chanOn);
endmodule

// File: rtl/ipt_datapath.sv
module ipt_datapath
  import ipt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countTick,
  input  ipt_strobe_t      stb,
  output logic [CNT_W-1:0] capData,
  output logic             capOvf,
  output logic             capIrq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic             wrapSeen;
  logic             tickNow;

  assign tickNow = stb.run & countTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      wrapSeen <= 1'b0;
      capData  <= '0;
      capOvf   <= 1'b0;
      capIrq   <= 1'b0;
    end else begin
      capIrq <= stb.capture;
      if (stb.start) begin
        cntQ     <= '0;
        wrapSeen <= 1'b0;
      end else if (stb.capture) begin
        capData  <= cntQ;
        capOvf   <= wrapSeen;
        cntQ     <= '0;
        wrapSeen <= 1'b0;
      end else if (tickNow) begin
        cntQ <= cntQ + CNT_ONE;
        if (cntQ == CNT_MAX) wrapSeen <= 1'b1;
      end
    end
  end

  // R3: pulse cycle shows the count from before the capture edge
  a_r3_load_match: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> capData == $past(cntQ));
  // R3: counter restarted on the capture edge
  a_r3_cleared: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> cntQ == '0);
  // R2: single step per tick while running
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.run && !stb.capture && !stb.start && countTick |=> cntQ == $past(cntQ) + CNT_ONE);
  // R8: counter frozen while off
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run && !stb.start |=> $stable(cntQ));
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer
  import ipt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countTick,
  input  logic             chanStartCap,
  input  logic             chanStop,
  input  logic             pinIn,
  input  logic [1:0]       edgeSel,
  input  logic             filtEn,
  output logic [CNT_W-1:0] capData,
  output logic             capOvf,
  output logic             capIrq,
  output logic             chanOn
);
  logic        edgeHit;
  ipt_strobe_t stb;

  ipt_input_cond #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN),
    .HAS_FILTER (1'b1)
  ) u_cond (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .filtEn (filtEn),
    .edgeSel(edgeSel),
    .edgeHit(edgeHit)
  );

  ipt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .swTrig (chanStartCap),
    .swStop (chanStop),
    .edgeHit(edgeHit),
    .chanOn (chanOn),
    .stb    (stb)
  );

  ipt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .countTick(countTick),
    .stb      (stb),
    .capData  (capData),
    .capOvf   (capOvf),
    .capIrq   (capIrq)
  );
endmodule

// File: tb/pulse_interval_timer_tb.sv
module pulse_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countTick = 1'b0;
  logic        chanStartCap = 1'b0;
  logic        chanStop = 1'b0;
  logic        pinIn = 1'b0;
  logic [1:0]  edgeSel = 2'b00;
  logic        filtEn = 1'b0;
  logic [15:0] capData;
  logic        capOvf;
  logic        capIrq;
  logic        chanOn;

  pulse_interval_timer u_dut (
    .clk(clk), .rstN(rstN), .countTick(countTick), .chanStartCap(chanStartCap),
    .chanStop(chanStop), .pinIn(pinIn), .edgeSel(edgeSel), .filtEn(filtEn),
    .capData(capData), .capOvf(capOvf), .capIrq(capIrq), .chanOn(chanOn)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  typedef struct {
    int          edgeNo;
    logic [15:0] data;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          cyc = 0;
  int          refEdge = 0;
  int          tickDiv = 1;
  int          compared = 0;
  int          mismatched = 0;
  logic [15:0] lastData = '0;
  logic        lastOvf = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  // tick seen at edge e is 1 when e is a multiple of tickDiv
  always @(negedge clk) countTick = ((cyc + 1) % tickDiv) == 0;

  function automatic void pushExp(int capEdge, string tag);
    exp_t it;
    int ticks = 0;
    for (int e = refEdge + 1; e < capEdge; e++)
      if (e % tickDiv == 0) ticks++;
    it.edgeNo = capEdge;
    it.data   = ticks[15:0];
    it.ovf    = (ticks >= 65536);
    it.tag    = tag;
    expQ.push_back(it);
    refEdge = capEdge;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare every capture pulse with the head of the queue
  always @(negedge clk) begin
    if (rstN && capIrq) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected capture at edge %0d actual=%0h expected=none", cyc, capData);
      end else begin
        exp_t it;
        it = expQ.pop_front();
        if (capData !== it.data || capOvf !== it.ovf || cyc != it.edgeNo) begin
          mismatched++;
          $display("FAIL %s actual data=%0h ovf=%0b edge=%0d expected data=%0h ovf=%0b edge=%0d",
                   it.tag, capData, capOvf, cyc, it.data, it.ovf, it.edgeNo);
        end
        lastData = it.data;
        lastOvf  = it.ovf;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic swStrobe(bit isStart, string tag);
    @(negedge clk);
    chanStartCap = 1'b1;
    if (isStart) refEdge = cyc + 1;
    else         pushExp(cyc + 1, tag);
    @(negedge clk);
    chanStartCap = 1'b0;
  endtask

  task automatic setPin(bit v, bit capExp, string tag);
    @(negedge clk);
    pinIn = v;
    if (capExp) pushExp(cyc + (filtEn ? 6 : 3), tag);
  endtask

  task automatic stopChan();
    @(negedge clk);
    chanStop = 1'b1;
    @(negedge clk);
    chanStop = 1'b0;
  endtask

  task automatic settle(string tag);
    idle(12);
    while (expQ.size() != 0) begin
      exp_t it;
      it = expQ.pop_front();
      compared++;
      mismatched++;
      $display("FAIL %s missing capture actual=none expected=%0h", it.tag, it.data);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(1);
    // R9 reset values
    chk(capData == 16'h0, "R9 capData", capData, 0);
    chk(capOvf == 1'b0 && capIrq == 1'b0, "R9 flags", {capOvf, capIrq}, 0);
    chk(chanOn == 1'b0, "R9 chanOn", chanOn, 0);

    // R1: edges before start are ignored
    edgeSel = 2'b11;
    setPin(1'b1, 1'b0, "R1");
    idle(6);
    setPin(1'b0, 1'b0, "R1");
    settle("R1");
    chk(capData == 16'h0, "R1 no capture while idle", capData, 0);

    swStrobe(1'b1, "R1");
    chk(chanOn == 1'b1, "R1 chanOn after start", chanOn, 1);

    // R3/R6 rising only
    edgeSel = 2'b01;
    idle(20);
    setPin(1'b1, 1'b1, "R3 rising capture");
    idle(30);
    setPin(1'b0, 1'b0, "R6");
    idle(15);
    setPin(1'b1, 1'b1, "R6 rising after ignored fall");
    settle("R6");

    // R5 software capture while running
    idle(7);
    swStrobe(1'b0, "R5 sw capture");
    swStrobe(1'b0, "R5 back-to-back sw capture");
    settle("R5");

    // R2 gated ticks
    stopChan();
    tickDiv = 3;
    swStrobe(1'b1, "R2");
    idle(40);
    swStrobe(1'b0, "R2 every third tick");
    idle(17);
    edgeSel = 2'b10;
    setPin(1'b0, 1'b1, "R6 falling capture");
    settle("R2");

    // R6 both edges
    edgeSel = 2'b11;
    setPin(1'b1, 1'b1, "R6 both rising");
    idle(9);
    setPin(1'b0, 1'b1, "R6 both falling");
    settle("R6");

    // R7 filter
    filtEn = 1'b1;
    idle(5);
    setPin(1'b1, 1'b0, "R7");
    idle(1);
    setPin(1'b0, 1'b0, "R7");
    settle("R7 glitch ignored");
    setPin(1'b1, 1'b1, "R7 filtered rise");
    idle(20);
    setPin(1'b0, 1'b1, "R7 filtered fall");
    settle("R7");
    filtEn = 1'b0;
    idle(5);

    // R4 overflow once, then refreshed to 0
    stopChan();
    tickDiv = 1;
    swStrobe(1'b1, "R4");
    idle(65540);
    swStrobe(1'b0, "R4 one wrap");
    idle(100);
    swStrobe(1'b0, "R4 flag refreshed");
    settle("R4");

    // R8 stop holds outputs, ignores edges
    @(negedge clk);
    chanStop = 1'b1;
    chanStartCap = 1'b1;
    @(negedge clk);
    chanStop = 1'b0;
    chanStartCap = 1'b0;
    chk(chanOn == 1'b0, "R8 stop wins", chanOn, 0);
    setPin(1'b1, 1'b0, "R8");
    idle(10);
    setPin(1'b0, 1'b0, "R8");
    settle("R8");
    chk(capData == lastData, "R8 capData held", capData, lastData);
    chk(capOvf == lastOvf, "R8 capOvf held", capOvf, lastOvf);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule